// File: doc/BRIEF.md
# UART line monitor flag unit

This unit sits beside a UART-style serial port and watches two things: the level on the receive pin and the bit the transmitter is currently driving. From them it keeps three sticky event flags. The first records an active edge on the receive input, with the polarity chosen by the port's receive-inversion control. The second records a transmit/receive mismatch seen at a sample strobe while bit checking is on, which catches collisions on a looped-back or shared line. The third records a break reported by the break detector while break checking is on.

Software reaches the flags through a status register and masks them through a control register. Both sit at their own two offsets, and only while the alternate-map select is high. Each flag is cleared by writing a one to its bit, and a single interrupt line is raised while any flag is set together with its enable. On a bit error the unit also stores the receive level it saw, which tells software in which direction the line was corrupted.

The receive pin is asynchronous to the unit's clock. It passes through a two-flop synchronizer before any use. The baud timing, shifters and break length counting are done elsewhere and appear here only as strobes.

Top module: `uart_line_flag_unit`

## Requirements
- R1: After reset both registers read 0x00 and `irq` is low.
- R2: Offset 0 is the status register: bit 7 edge flag, bit 2 bit-error level, bit 1 bit-error flag, bit 0 break flag, bits 6..3 read 0. Offset 1 is the control register: bit 7 edge enable, bit 1 bit-error enable, bit 0 break enable, other bits read 0 and ignore writes.
- R3: With `rx_invert` = 0 a falling edge of the synchronized receive level sets the edge flag, and a rising edge does not. With `rx_invert` = 1 a rising edge sets it, and a falling edge does not.
- R4: When `sample_stb` is high, `bit_check_en` is high and the synchronized receive level differs from `tx_bit`, the bit-error flag sets. With `bit_check_en` low, or with equal levels, it does not set.
- R5: The bit-error level field takes the synchronized receive level only in a cycle where the bit-error flag goes from 0 to 1. Otherwise it holds its value (0 = low seen, high expected; 1 = high seen, low expected).
- R6: A `brk_pulse` sets the break flag only while `brk_check_en` is high.
- R7: Writing status with a 1 in a flag bit clears that flag. A 0 leaves the flag unchanged, and writes to bit 2 and bits 6..3 have no effect.
- R8: If a set event and a clearing write hit the same flag in one cycle, the flag ends up 1.
- R9: `irq` is high exactly when some flag is set and its enable bit is 1.
- R10: While `alt_sel` is 0, writes change neither register and `reg_rdata` reads 0x00.
- R11: A change on `rx_line` can set the edge flag no earlier than the third rising clock edge after it. The flag reads 0 after two edges and 1 after three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous receive pin level |
| rx_invert | input | 1 | Active edge select: 0 falling, 1 rising |
| bit_check_en | input | 1 | Enables transmit/receive mismatch checking |
| sample_stb | input | 1 | One-cycle strobe at the bit sampling point |
| tx_bit | input | 1 | Bit currently being transmitted |
| brk_check_en | input | 1 | Enables break flagging |
| brk_pulse | input | 1 | One-cycle break-detected pulse |
| alt_sel | input | 1 | Alternate-map select; registers reachable when 1 |
| reg_addr | input | 1 | Register offset: 0 status, 1 control |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `sample_stb` and `brk_pulse` come from synchronous logic, and that `rx_invert` only changes while the synchronized receive level is steady. The bench keeps to both. Every strobe and pulse lasts exactly one cycle, and the polarity is changed only after the receive pin has been still for several cycles. The pin is also held still across each sample strobe, so the bench's model knows which level the unit compared. Random register writes, strobes, pin toggles and break pulses are issued one at a time. Only the directed set-versus-clear case lets two of them meet in one cycle.

// File: rtl/uart_lmf_pkg.sv
// Package: register offsets, bit positions and flag indices shared by the
// line monitor flag unit and its sub-blocks.
package uart_lmf_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 1;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 1'b1;

    // Bit positions shared by the status and control images.
    localparam int BIT_EDGE = 7;
    localparam int BIT_BVAL = 2;
    localparam int BIT_BERR = 1;
    localparam int BIT_BRK  = 0;

    // Flag indices inside the flag bank.
    localparam int NUM_FLAGS = 3;
    localparam int FL_BRK    = 0;
    localparam int FL_BERR   = 1;
    localparam int FL_EDGE   = 2;

    // Register bit that owns a given flag index.
    function automatic int flag_bit(input int idx);
        case (idx)
            FL_BRK:  return BIT_BRK;
            FL_BERR: return BIT_BERR;
            default: return BIT_EDGE;
        endcase
    endfunction

endpackage

// File: rtl/lmf_sync.sv
// Multi-stage synchronizer for an asynchronous single-bit input.
// Assumes STAGES >= 2; output lags the input by STAGES clocks.
module lmf_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/lmf_edge_det.sv
// Active edge detector on a synchronized level. pol = 0 selects falling
// edges, pol = 1 rising edges. Assumes pol is steady around an edge.
module lmf_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic pol,
    output logic edge_pulse
);
    logic prev_q;

    // Remember the previous synchronized sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl;
    end

    // An edge is active when the level changed to the level named by pol.
    assign edge_pulse = (prev_q != lvl) && (lvl == pol);

    p_fall_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pol && $fell(lvl)) |-> edge_pulse);
    p_rise_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pol && $rose(lvl)) |-> edge_pulse);
    p_no_edge_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(lvl) |-> !edge_pulse);
endmodule

// File: rtl/lmf_bit_check.sv
// Compares the synchronized receive level with the transmitted bit at the
// sample strobe. Assumes sample_stb is a one-cycle synchronous strobe.
module lmf_bit_check (
    input  logic clk,
    input  logic rst_n,
    input  logic check_en,
    input  logic sample_stb,
    input  logic rx_lvl,
    input  logic tx_bit,
    output logic err_pulse,
    output logic err_level
);
    // Mismatch only counts at an enabled sample point.
    assign err_pulse = check_en && sample_stb && (rx_lvl != tx_bit);
    assign err_level = rx_lvl;

    p_no_err_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!check_en || !sample_stb) |-> !err_pulse);
    p_err_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (err_level == !tx_bit));
endmodule

// File: rtl/lmf_flag_bank.sv
// Bank of sticky write-one-to-clear flags with per-flag enables and a
// combined interrupt. Set takes priority over clear in the same cycle.
module lmf_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] flag_o,
    output logic         irq_o
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        // Sticky flag: set wins, then clear, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_o[i] <= 1'b0;
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (clr_i[i]) flag_o[i] <= 1'b0;
        end

        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_o[i]);
        p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
        p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
        p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[i] && en_i[i]) |-> irq_o);
    end

    // Interrupt when any enabled flag is set.
    assign irq_o = |(flag_o & en_i);

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o == '0) |-> !irq_o);
endmodule

// File: rtl/uart_line_flag_unit.sv
// Top of the UART line monitor flag unit: synchronizes the receive pin,
// detects active edges, bit errors and breaks, keeps sticky flags with
// enables, and serves the status/control registers when alt_sel is 1.
// Assumes strobes and register accesses are synchronous to clk.
module uart_line_flag_unit
    import uart_lmf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              rx_invert,
    input  logic              bit_check_en,
    input  logic              sample_stb,
    input  logic              tx_bit,
    input  logic              brk_check_en,
    input  logic              brk_pulse,
    input  logic              alt_sel,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    logic                 rx_s;
    logic                 edge_pulse;
    logic                 err_pulse;
    logic                 err_level;
    logic [NUM_FLAGS-1:0] set_v;
    logic [NUM_FLAGS-1:0] clr_v;
    logic [NUM_FLAGS-1:0] en_q;
    logic [NUM_FLAGS-1:0] flags;
    logic                 bval_q;
    logic                 wr_status;
    logic                 wr_ctrl;
    logic [REG_W-1:0]     status_img;
    logic [REG_W-1:0]     ctrl_img;

    lmf_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line),
        .dout  (rx_s)
    );

    lmf_edge_det u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (rx_s),
        .pol        (rx_invert),
        .edge_pulse (edge_pulse)
    );

    lmf_bit_check u_bchk (
        .clk        (clk),
        .rst_n      (rst_n),
        .check_en   (bit_check_en),
        .sample_stb (sample_stb),
        .rx_lvl     (rx_s),
        .tx_bit     (tx_bit),
        .err_pulse  (err_pulse),
        .err_level  (err_level)
    );

    // Register write decode, gated by the alternate-map select.
    assign wr_status = alt_sel && reg_wr && (reg_addr == ADDR_STATUS);
    assign wr_ctrl   = alt_sel && reg_wr && (reg_addr == ADDR_CTRL);

    // Route event sources and write-one-to-clear bits to the flag bank.
    always_comb begin
        set_v          = '0;
        set_v[FL_EDGE] = edge_pulse;
        set_v[FL_BERR] = err_pulse;
        set_v[FL_BRK]  = brk_check_en && brk_pulse;
        for (int i = 0; i < NUM_FLAGS; i++)
            clr_v[i] = wr_status && reg_wdata[flag_bit(i)];
    end

    lmf_flag_bank #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .en_i   (en_q),
        .flag_o (flags),
        .irq_o  (irq)
    );

    // Control register: one enable per flag.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else if (wr_ctrl)
            for (int i = 0; i < NUM_FLAGS; i++)
                en_q[i] <= reg_wdata[flag_bit(i)];
    end

    // Capture the receive level only when a new bit error is raised.
    always_ff @(posedge clk) begin
        if (!rst_n) bval_q <= 1'b0;
        else if (err_pulse && !flags[FL_BERR]) bval_q <= err_level;
    end

    // Assemble register images and the read mux.
    always_comb begin
        status_img           = '0;
        status_img[BIT_EDGE] = flags[FL_EDGE];
        status_img[BIT_BVAL] = bval_q;
        status_img[BIT_BERR] = flags[FL_BERR];
        status_img[BIT_BRK]  = flags[FL_BRK];
        ctrl_img             = '0;
        for (int i = 0; i < NUM_FLAGS; i++)
            ctrl_img[flag_bit(i)] = en_q[i];
        reg_rdata = '0;
        if (alt_sel)
            reg_rdata = (reg_addr == ADDR_STATUS) ? status_img : ctrl_img;
    end

    p_alt_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!alt_sel && reg_wr && !err_pulse && !edge_pulse && !brk_pulse)
        |=> ($stable(en_q) && $stable(flags)));
    p_alt_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_sel |-> (reg_rdata == '0));
    p_bval_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FL_BERR] || !err_pulse) |=> $stable(bval_q));
    p_bval_new_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && !flags[FL_BERR]) |=> (bval_q == !$past(tx_bit)));
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_sel && reg_addr == ADDR_STATUS) |-> (reg_rdata[6:3] == 4'b0));
endmodule

// File: tb/tb_uart_line_flag_unit.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared with a bench-side model of the flags, level field and enables.
module tb_uart_line_flag_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1, rx_invert = 1'b0;
    logic       bit_check_en = 1'b0, sample_stb = 1'b0, tx_bit = 1'b1;
    logic       brk_check_en = 1'b0, brk_pulse = 1'b0;
    logic       alt_sel = 1'b1, reg_addr = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_tests = 0, n_fail = 0;
    logic m_edge = 0, m_berr = 0, m_bval = 0, m_brk = 0;
    logic m_en_edge = 0, m_en_berr = 0, m_en_brk = 0;
    int unsigned seed_sink;

    always #4 clk = ~clk;

    uart_line_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_invert(rx_invert),
        .bit_check_en(bit_check_en), .sample_stb(sample_stb), .tx_bit(tx_bit),
        .brk_check_en(brk_check_en), .brk_pulse(brk_pulse), .alt_sel(alt_sel),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq));

    function automatic logic [7:0] exp_status();
        return {m_edge, 4'b0000, m_bval, m_berr, m_brk};
    endfunction
    function automatic logic [7:0] exp_ctrl();
        return {m_en_edge, 5'b00000, m_en_berr, m_en_brk};
    endfunction
    function automatic logic exp_irq();
        return (m_edge & m_en_edge) | (m_berr & m_en_berr) | (m_brk & m_en_brk);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Read both registers and irq; called in the negedge phase.
    task automatic check_all(input string req);
        alt_sel = 1'b1; reg_addr = 1'b0; #1;
        chk({req, " status"}, reg_rdata, exp_status());
        reg_addr = 1'b1; #1;
        chk({req, " control"}, reg_rdata, exp_ctrl());
        chk({req, " irq"}, {7'b0, irq}, {7'b0, exp_irq()});
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d, input logic sel);
        alt_sel = sel; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; alt_sel = 1'b1;
        if (sel) begin
            if (a == 1'b0) begin
                if (d[7]) m_edge = 0;
                if (d[1]) m_berr = 0;
                if (d[0]) m_brk = 0;
            end else begin
                m_en_edge = d[7]; m_en_berr = d[1]; m_en_brk = d[0];
            end
        end
    endtask

    task automatic drive_rx(input logic v);
        if (v != rx_line && v == rx_invert) m_edge = 1;
        rx_line = v;
        repeat (4) tick();
    endtask

    task automatic strobe(input logic tx, input logic en);
        tx_bit = tx; bit_check_en = en; sample_stb = 1'b1;
        tick();
        sample_stb = 1'b0;
        if (en && rx_line != tx) begin
            if (!m_berr) m_bval = rx_line;
            m_berr = 1;
        end
    endtask

    task automatic brk(input logic en);
        brk_check_en = en; brk_pulse = 1'b1;
        tick();
        brk_pulse = 1'b0;
        if (en) m_brk = 1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        seed_sink = $urandom(32'd20813);
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check_all("R1 reset");

        // R2: layout of the control register; unused bits read zero.
        write_reg(1'b1, 8'hFF, 1'b1);
        check_all("R2 ctrl all ones");
        chk("R2 ctrl image", exp_ctrl(), 8'h83);
        write_reg(1'b1, 8'h00, 1'b1);
        check_all("R2 ctrl cleared");

        // R10: writes with alt_sel low are ignored, reads give zero.
        write_reg(1'b1, 8'hFF, 1'b0);
        check_all("R10 ignored write");
        alt_sel = 1'b0; #1;
        chk("R10 read zero", reg_rdata, 8'h00);
        alt_sel = 1'b1;

        // R3/R11: falling edge with polarity 0, including sync latency.
        rx_line = 1'b0;
        tick(); tick();
        check_all("R11 not yet after two edges");
        tick();
        m_edge = 1;
        check_all("R11 set after three edges");
        tick();
        write_reg(1'b0, 8'h80, 1'b1);
        check_all("R7 clear edge");
        drive_rx(1'b1);
        check_all("R3 rising ignored pol0");
        rx_invert = 1'b1; tick();
        drive_rx(1'b0);
        check_all("R3 falling ignored pol1");
        drive_rx(1'b1);
        check_all("R3 rising sets pol1");
        rx_invert = 1'b0; tick();

        // R7: writing zeros and the level bit leaves flags alone.
        write_reg(1'b0, 8'h7C, 1'b1);
        check_all("R7 zero write keeps flag");

        // R4/R5: bit error capture and hold.
        strobe(1'b0, 1'b0);
        check_all("R4 disabled no error");
        strobe(1'b1, 1'b1);
        check_all("R4 equal no error");
        drive_rx(1'b0);
        strobe(1'b1, 1'b1);
        check_all("R4 low seen high expected");
        chk("R5 level low", {7'b0, m_bval}, 8'h00);
        drive_rx(1'b1);
        strobe(1'b0, 1'b1);
        check_all("R5 level held while set");
        write_reg(1'b0, 8'h02, 1'b1);
        check_all("R5 level kept after clear");
        strobe(1'b0, 1'b1);
        check_all("R5 new error captures high");

        // R6: break flag only with enable.
        brk(1'b0);
        check_all("R6 break disabled");
        brk(1'b1);
        check_all("R6 break enabled");

        // R9: interrupt follows enables.
        write_reg(1'b1, 8'h01, 1'b1);
        check_all("R9 break enabled irq");
        write_reg(1'b1, 8'h80, 1'b1);
        check_all("R9 edge enable with flag set");

        // R8: clear and set of the break flag in the same cycle.
        alt_sel = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h01; reg_wr = 1'b1;
        brk_check_en = 1'b1; brk_pulse = 1'b1;
        tick();
        reg_wr = 1'b0; brk_pulse = 1'b0;
        m_brk = 1;
        check_all("R8 set wins over clear");

        // Random traffic, one action at a time.
        for (int it = 0; it < 400; it++) begin
            int unsigned op = $urandom_range(0, 6);
            case (op)
                0: drive_rx(~rx_line);
                1: begin rx_invert = $urandom_range(0, 1); tick(); end
                2: strobe(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
                3: brk(1'($urandom_range(0, 1)));
                4: write_reg(1'b0, 8'($urandom_range(0, 255)), 1'b1);
                5: write_reg(1'b1, 8'($urandom_range(0, 255)), 1'b1);
                default: write_reg(1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)), 1'b0);
            endcase
            check_all("R3 R4 R5 R6 R7 R9 R10 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule